// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sender

This block holds the two 32-bit command words that one processor uses to send an interrupt message to other processors. Software first writes the destination into the high command word and then writes the low command word. The low-word write is what launches the message: its vector, delivery mode, trigger mode and destination shorthand, together with the destination taken from the high word, are captured and presented on a valid/ready message port.

A busy bit in the low word reads as 1 from the launch until the receiver takes the message with a valid/ready handshake. Software polls this bit before it sends again. A low-word write that cannot be honoured leaves a sticky error bit set instead of being lost silently. This covers a write made while busy and a write carrying the reserved delivery mode. The high word is a plain storage register. Software may save it before a send and restore it afterwards.

On the message port, `msg_valid` rises in the cycle after the launching write. While `msg_ready` is low, `msg_valid` and every message field stay unchanged. The message is consumed on the first rising clock edge where both are high. `msg_ready` may be held high at any time.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, both command words read as 0 and `msg_valid` is 0.
- R2: A write to the high word (offset HI_OFS) stores bits 31:24 as the 8-bit destination, and the other bits read back as 0. A high-word write never launches a message.
- R3: A low-word write (offset LO_OFS) made while idle launches a message in the next cycle. The message carries vector = bits 7:0, delivery mode = bits 10:8, trigger = bit 15 and shorthand = bits 19:18. Its level is always 1, whatever bit 14 of the written word holds.
- R4: If shorthand = 0 (explicit destination), `msg_dest` equals the stored high-word destination at launch. For any nonzero shorthand (1 self, 2 all, 3 all but self), `msg_dest` is 0 and the stored destination is ignored.
- R5: The low word reads as {err[31], 0, shorthand[19:18], 0, trigger[15], level[14], 0, busy[12], 0, mode[10:8], vector[7:0]}. The busy bit is 1 from the cycle after a launch until the cycle after the handshake.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and all message fields hold their values.
- R7: A low-word write made while busy launches nothing, leaves the message and the stored fields unchanged, and sets the sticky error bit 31.
- R8: A low-word write with delivery mode 3 (reserved) launches nothing and sets the error bit. Modes 0 fixed, 1 lowest priority, 2 system management, 4 NMI, 5 INIT, 6 startup and 7 external are all accepted.
- R9: A low-word write with bit 31 = 1 clears the error bit and launches nothing.
- R10: An access is honoured only if `bus_size` = 2'b10 (32 bits) and bus_addr[3:0] = 0. Any other access is ignored and reads as 0. A read of any offset other than the two command words also returns 0.
- R11: The high word keeps its value across launches and handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code, 2'b10 = 32 bits |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| msg_valid | output | 1 | Message pending (the busy bit) |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level bit, always 1 on a message |
| msg_trigger | output | 1 | Trigger mode, 1 = level-triggered |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | 8 | Destination ID, 0 when a shorthand is used |

## Verification
The hardest case to reach is a low-word write that lands while a message is still waiting. Software that follows the protocol never does this. The bench creates it on purpose: it holds `msg_ready` low after each launch, issues a second low-word write with a different vector, and only then lets the handshake through. It then checks the sticky error bit and its explicit clear. Every delivery mode, shorthand and trigger combination is swept, including the reserved mode. The back-pressure wait length varies with each combination.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;

  // low command word bit positions
  localparam int B_MODE  = 8;
  localparam int B_BUSY  = 12;
  localparam int B_LEVEL = 14;
  localparam int B_TRIG  = 15;
  localparam int B_SH    = 18;
  localparam int B_ERR   = 31;
  // high command word destination position
  localparam int B_DEST  = 24;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMM    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    dmode_e            mode;
    logic              level;
    logic              trigger;
    short_e            shorthand;
    logic [DEST_W-1:0] dest;
  } ipi_msg_t;
endpackage

// File: rtl/ipi_regdec.sv
module ipi_regdec #(
  parameter int ADDR_W = 12,
  parameter int unsigned LO_OFS = 'h300,
  parameter int unsigned HI_OFS = 'h310
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              lo_rd,
  output logic              hi_rd
);
  import ipi_pkg::*;

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_OFS);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_OFS);

  logic legal;
  logic lo_hit;
  logic hi_hit;

  // whole-word, 16-byte aligned accesses only
  assign legal  = bus_sel && (bus_size == SIZE_WORD) && (bus_addr[3:0] == 4'h0);
  assign lo_hit = legal && (bus_addr == LO_A);
  assign hi_hit = legal && (bus_addr == HI_A);

  assign lo_wr = lo_hit &&  bus_we;
  assign hi_wr = hi_hit &&  bus_we;
  assign lo_rd = lo_hit && !bus_we;
  assign hi_rd = hi_hit && !bus_we;
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic [31:0]       wdata,
  input  logic [DEST_W-1:0] hi_dest,
  input  logic              msg_ready,
  output ipi_msg_t          msg,
  output logic              busy,
  output logic              err
);
  ipi_msg_t nxt;
  logic     clr;
  logic     bad_mode;
  logic     launch;
  logic     reject;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[30:20], wdata[17:16], wdata[14:11]};

  always_comb begin
    nxt.vector    = wdata[VEC_W-1:0];
    nxt.mode      = dmode_e'(wdata[B_MODE+2:B_MODE]);
    nxt.level     = 1'b1;
    nxt.trigger   = wdata[B_TRIG];
    nxt.shorthand = short_e'(wdata[B_SH+1:B_SH]);
    nxt.dest      = (nxt.shorthand == SH_NONE) ? hi_dest : '0;
  end

  assign clr      = lo_wr && wdata[B_ERR];
  assign bad_mode = (wdata[B_MODE+2:B_MODE] == DM_RSVD);
  assign launch   = lo_wr && !clr && !busy && !bad_mode;
  assign reject   = lo_wr && !clr && (busy || bad_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg  <= '0;
      busy <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (launch) begin
        msg  <= nxt;
        busy <= 1'b1;
      end else if (busy && msg_ready) begin
        busy <= 1'b0;
      end
      if (clr)         err <= 1'b0;
      else if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_rdmux.sv
module ipi_rdmux
  import ipi_pkg::*;
(
  input  logic              lo_rd,
  input  logic              hi_rd,
  input  ipi_msg_t          msg,
  input  logic              busy,
  input  logic              err,
  input  logic [DEST_W-1:0] hi_dest,
  output logic [31:0]       rdata
);
  logic [31:0] lo_word;
  logic        unused_dest;

  assign unused_dest = ^msg.dest;

  always_comb begin
    lo_word                  = '0;
    lo_word[VEC_W-1:0]       = msg.vector;
    lo_word[B_MODE+2:B_MODE] = msg.mode;
    lo_word[B_BUSY]          = busy;
    lo_word[B_LEVEL]         = msg.level;
    lo_word[B_TRIG]          = msg.trigger;
    lo_word[B_SH+1:B_SH]     = msg.shorthand;
    lo_word[B_ERR]           = err;
  end

  always_comb begin
    rdata = '0;
    if (lo_rd)      rdata = lo_word;
    else if (hi_rd) rdata = {hi_dest, {B_DEST{1'b0}}};
  end
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender #(
  parameter int ADDR_W = 12,
  parameter int unsigned LO_OFS = 'h300,
  parameter int unsigned HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [1:0]        msg_shorthand,
  output logic [7:0]        msg_dest
);
  import ipi_pkg::*;

  logic              lo_wr, hi_wr, lo_rd, hi_rd;
  logic [DEST_W-1:0] hi_dest;
  ipi_msg_t          msg;
  logic              busy, err;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[B_DEST-1:0];

  ipi_regdec #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .lo_rd(lo_rd), .hi_rd(hi_rd)
  );

  // high command word: destination storage only, never launches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_dest <= '0;
    else if (hi_wr) hi_dest <= bus_wdata[31:B_DEST];
  end

  ipi_launch u_launch (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .wdata(bus_wdata),
    .hi_dest(hi_dest), .msg_ready(msg_ready),
    .msg(msg), .busy(busy), .err(err)
  );

  ipi_rdmux u_rd (
    .lo_rd(lo_rd), .hi_rd(hi_rd), .msg(msg), .busy(busy), .err(err),
    .hi_dest(hi_dest), .rdata(bus_rdata)
  );

  assign msg_valid     = busy;
  assign msg_vector    = msg.vector;
  assign msg_mode      = msg.mode;
  assign msg_level     = msg.level;
  assign msg_trigger   = msg.trigger;
  assign msg_shorthand = msg.shorthand;
  assign msg_dest      = msg.dest;
endmodule

// File: rtl/ipi_cmd_sender_chk.sv
module ipi_cmd_sender_chk #(
  parameter int ADDR_W = 12,
  parameter int unsigned LO_OFS = 'h300,
  parameter int unsigned HI_OFS = 'h310
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic              msg_level,
  input logic              msg_trigger,
  input logic [1:0]        msg_shorthand,
  input logic [7:0]        msg_dest
);
  logic good, lo_w, hi_w, lo_r;
  assign good = bus_sel && (bus_size == 2'b10) && (bus_addr[3:0] == 4'h0);
  assign lo_w = good && bus_we && (bus_addr == ADDR_W'(LO_OFS));
  assign hi_w = good && bus_we && (bus_addr == ADDR_W'(HI_OFS));
  assign lo_r = good && !bus_we && (bus_addr == ADDR_W'(LO_OFS));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_mode)
      && $stable(msg_trigger) && $stable(msg_shorthand) && $stable(msg_dest));

  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_level);

  p_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_shorthand != 2'd0) |-> (msg_dest == 8'd0));

  p_hi_nolaunch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_w && !msg_valid |=> !msg_valid);

  p_busy_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_r |-> (bus_rdata[12] == msg_valid));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  p_mode_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_w && !msg_valid && (bus_wdata[10:8] == 3'd3) |=> !msg_valid);

  p_clear_nolaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_w && !msg_valid && bus_wdata[31] |=> !msg_valid);

  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !good && !msg_valid |=> !msg_valid);
endmodule

bind ipi_cmd_sender ipi_cmd_sender_chk #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_size(bus_size),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
  .msg_mode(msg_mode), .msg_level(msg_level), .msg_trigger(msg_trigger),
  .msg_shorthand(msg_shorthand), .msg_dest(msg_dest)
);

// File: tb/ipi_cmd_sender_test.sv
module ipi_cmd_sender_test;
  localparam int AW = 12;
  localparam logic [AW-1:0] LO = 12'h300;
  localparam logic [AW-1:0] HI = 12'h310;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 2'b10;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic msg_valid, msg_ready = 0;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;
  logic msg_level, msg_trigger;
  logic [1:0] msg_shorthand;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ipi_cmd_sender uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_level(msg_level), .msg_trigger(msg_trigger),
    .msg_shorthand(msg_shorthand), .msg_dest(msg_dest)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_size = 2'b10;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #2 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0; bus_size = 2'b10;
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  function automatic logic [31:0] lo_exp(logic [7:0] v, logic [2:0] m, logic lv, logic t,
                                         logic [1:0] s, logic b, logic e);
    return {e, 11'd0, s, 2'b00, t, lv, 1'b0, b, 1'b0, m, v};
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] pv; logic [2:0] pm; logic pl, pt; logic [1:0] ps;
    pv = 0; pm = 0; pl = 0; pt = 0; ps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(LO, 2'b10, r); chk("R1 low word", r, 32'h0);
    rd(HI, 2'b10, r); chk("R1 high word", r, 32'h0);
    chk("R1 msg_valid", {31'd0, msg_valid}, 32'd0);

    // R2 high word storage only
    wr(HI, 32'hA5FF_FFFF, 2'b10);
    chk("R2 no launch", {31'd0, msg_valid}, 32'd0);
    rd(HI, 2'b10, r); chk("R2 high readback", r, 32'hA500_0000);

    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 2; t++) begin
          logic [7:0] v, d, de;
          logic [31:0] w;
          v = 8'((m * 37 + s * 11 + t * 101 + 5) & 255);
          d = 8'((m * 29 + s * 7 + t * 3 + 1) & 255);
          w = (32'(s) << 18) | (32'(t) << 15) | (32'(m) << 8) | 32'(v);
          wr(HI, {d, 24'hFFFFFF}, 2'b10);
          wr(LO, w, 2'b10);
          if (m == 3) begin
            chk("R8 reserved mode no launch", {31'd0, msg_valid}, 32'd0);
            rd(LO, 2'b10, r); chk("R8 error set", r, lo_exp(pv, pm, pl, pt, ps, 1'b0, 1'b1));
            wr(LO, 32'h8000_0000, 2'b10);
            chk("R9 clear no launch", {31'd0, msg_valid}, 32'd0);
            rd(LO, 2'b10, r); chk("R9 error cleared", r, lo_exp(pv, pm, pl, pt, ps, 1'b0, 1'b0));
          end else begin
            de = (s == 0) ? d : 8'd0;
            chk("R3 launch", {31'd0, msg_valid}, 32'd1);
            chk("R3 fields", {15'd0, msg_vector, msg_mode, msg_trigger, msg_shorthand, msg_level},
                {15'd0, v, 3'(m), 1'(t), 2'(s), 1'b1});
            chk("R4 dest", {24'd0, msg_dest}, {24'd0, de});
            rd(LO, 2'b10, r); chk("R5 busy readback", r, lo_exp(v, 3'(m), 1'b1, 1'(t), 2'(s), 1'b1, 1'b0));
            wr(LO, w ^ 32'h0000_00FF, 2'b10);
            chk("R7 busy write ignored", {23'd0, msg_valid, msg_vector}, {23'd0, 1'b1, v});
            rd(LO, 2'b10, r); chk("R7 error flagged", r, lo_exp(v, 3'(m), 1'b1, 1'(t), 2'(s), 1'b1, 1'b1));
            repeat ((m + s + t) % 3) @(negedge clk);
            chk("R6 held under backpressure", {15'd0, msg_valid, msg_vector, msg_dest},
                {15'd0, 1'b1, v, de});
            accept();
            chk("R5 idle after handshake", {31'd0, msg_valid}, 32'd0);
            rd(LO, 2'b10, r); chk("R5 busy cleared", r, lo_exp(v, 3'(m), 1'b1, 1'(t), 2'(s), 1'b0, 1'b1));
            wr(LO, 32'h8000_0000, 2'b10);
            chk("R9 clear no launch", {31'd0, msg_valid}, 32'd0);
            rd(LO, 2'b10, r); chk("R9 error cleared", r, lo_exp(v, 3'(m), 1'b1, 1'(t), 2'(s), 1'b0, 1'b0));
            rd(HI, 2'b10, r); chk("R11 high kept", r, {d, 24'd0});
            pv = v; pm = 3'(m); pl = 1'b1; pt = 1'(t); ps = 2'(s);
          end
        end
      end
    end

    // R10 illegal accesses
    wr(LO, 32'h0000_0042, 2'b01);
    chk("R10 narrow write ignored", {31'd0, msg_valid}, 32'd0);
    wr(LO + 12'h4, 32'h0000_0042, 2'b10);
    chk("R10 misaligned write ignored", {31'd0, msg_valid}, 32'd0);
    wr(HI + 12'h8, 32'h1100_0000, 2'b10);
    rd(HI, 2'b10, r); chk("R10 misaligned high write ignored", r, {8'((7 * 29 + 3 * 7 + 3 + 1) & 255), 24'd0});
    rd(LO, 2'b00, r); chk("R10 narrow read zero", r, 32'h0);
    rd(LO + 12'h8, 2'b10, r); chk("R10 misaligned read zero", r, 32'h0);
    rd(12'h020, 2'b10, r); chk("R10 other offset zero", r, 32'h0);
    rd(LO, 2'b10, r); chk("R10 low intact", r, lo_exp(pv, pm, pl, pt, ps, 1'b0, 1'b0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule